// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block turns the 24-bit byte address of a 16-bit CPU with an asynchronous strobe-based bus into active-low chip selects for three targets: a boot ROM high in the map, local RAM at the bottom of the map, and a 1 MB window that passes accesses through to the backplane slots. Any strobed access that lands on none of these targets raises an unmapped flag, which a separate bus-error unit can act on.

Right after reset the CPU fetches its initial stack pointer and program counter from the first eight bytes of the map. A one-bit overlay, set by reset, steers reads of those eight bytes to the start of ROM. Writes to the same bytes still reach RAM, so boot code can copy its vectors down while the overlay is on. A data-strobed write to a fixed control address inside the IO window then clears the overlay. From that point the bottom of the map is plain RAM until the next reset.

The CPU word address arrives on `addr`. Bit 0 of the byte address is implied by the upper and lower data strobes. Only the control write depends on those strobes; the selects depend only on the address strobe.

Top module: `boot_map_decoder`

## Requirements
- R1: While `as_n` is high, all three selects are high and `unmapped` is low, whatever the address.
- R2: With `as_n` low, and with the overlay off or the access outside the vector bytes, each region drives its own select low. RAM covers bytes 0x000000–0x03FFFF and uses `ram_sel_n`. The backplane window covers 0x400000–0x4FFFFF and uses `io_sel_n`. ROM covers 0xFE0000–0xFFFFFF and uses `rom_sel_n`. A select is low only for its own region.
- R3: While the overlay is on, a read (`rw` = 1) of bytes 0x000000–0x000007 drives `rom_sel_n` low and leaves `ram_sel_n` high. A read at byte 0x000008 selects RAM.
- R4: A write (`rw` = 0) to bytes 0x000000–0x000007 selects RAM and not ROM, whether or not the overlay is on.
- R5: Reset (`rst_n` low) turns the overlay on. It turns off at the rising clock edge at which `as_n` is low, `rw` is 0, at least one of `uds_n`/`lds_n` is low, and the byte address is 0x4FFFFE. It stays off until the next reset.
- R6: With `as_n` low and no region hit, `unmapped` is 1. At most one of the three selects and `unmapped` is active in any cycle.
- R7: A read of the control address, or a write to it with both `uds_n` and `lds_n` high, leaves the overlay on.
- R8: `rom_off` is byte-address bits [16:1], the word offset inside the 128 KB ROM window. A vector read under the overlay therefore reaches ROM words 0–3 with the low address bits unchanged.
- R9: An access to the control address also selects the backplane window (`io_sel_n` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the overlay bit updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; sets the overlay |
| addr | input | 23 | CPU word address, byte-address bits [23:1] |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| rom_sel_n | output | 1 | Boot ROM select, active low |
| ram_sel_n | output | 1 | Local RAM select, active low |
| io_sel_n | output | 1 | Backplane window select, active low |
| unmapped | output | 1 | Strobed access that hits no region |
| rom_off | output | 16 | Word offset inside the ROM window |

## Verification
Two functions can act in the same cycle and in cycles right next to each other: the overlay being cleared, and the steering of the vector bytes that depends on it. The bench issues the control write, then reads a vector address in the very next cycle. That read must already go to RAM, while reads before the clearing edge went to ROM. Vector writes are also mixed in between overlaid vector reads, and must reach RAM in the same cycles in which reads of the same bytes reach ROM. A behavioural model tracks the overlay from the bench's own stimulus and judges every cycle, including random traffic that sometimes hits the control address with random strobes.

// File: rtl/boot_map_decoder.sv
module boot_map_decoder #(
  parameter int ADDR_W    = 24,
  parameter int RAM_BYTES = 32'h0004_0000,
  parameter int IO_BASE   = 32'h0040_0000,
  parameter int IO_BYTES  = 32'h0010_0000,
  parameter int ROM_BASE  = 32'h00FE_0000,
  parameter int ROM_BYTES = 32'h0002_0000,
  parameter int VEC_BYTES = 8,
  parameter int CTRL_ADDR = 32'h004F_FFFE,
  localparam int ROM_OFF_W = $clog2(ROM_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:1]      addr,
  input  logic                   as_n,
  input  logic                   rw,
  input  logic                   uds_n,
  input  logic                   lds_n,
  output logic                   rom_sel_n,
  output logic                   ram_sel_n,
  output logic                   io_sel_n,
  output logic                   unmapped,
  output logic [ROM_OFF_W-1:1]   rom_off
);

  localparam int AW1 = ADDR_W + 1;
  localparam logic [ADDR_W:0] RAM_HI = AW1'(RAM_BYTES);
  localparam logic [ADDR_W:0] IO_LO  = AW1'(IO_BASE);
  localparam logic [ADDR_W:0] IO_HI  = AW1'(IO_BASE + IO_BYTES);
  localparam logic [ADDR_W:0] ROM_LO = AW1'(ROM_BASE);
  localparam logic [ADDR_W:0] ROM_HI = AW1'(ROM_BASE + ROM_BYTES);
  localparam logic [ADDR_W:0] VEC_HI = AW1'(VEC_BYTES);
  localparam logic [ADDR_W:0] CTRL_B = AW1'(CTRL_ADDR);

  logic [ADDR_W:0] ba;
  logic in_ram, in_io, in_rom, in_vec, is_ctrl;
  logic active, any_ds, steer, ctrl_wr;
  logic rom_hit, ram_hit, io_hit;
  logic ovl_q;

  assign ba      = {1'b0, addr, 1'b0};
  assign in_ram  = ba < RAM_HI;
  assign in_io   = (ba >= IO_LO) && (ba < IO_HI);
  assign in_rom  = (ba >= ROM_LO) && (ba < ROM_HI);
  assign in_vec  = ba < VEC_HI;
  assign is_ctrl = ba == CTRL_B;

  assign active  = !as_n;
  assign any_ds  = !uds_n || !lds_n;
  assign steer   = ovl_q && rw && in_vec;
  assign ctrl_wr = active && !rw && any_ds && is_ctrl;

  assign rom_hit = in_rom || steer;
  assign ram_hit = in_ram && !steer;
  assign io_hit  = in_io;

  assign rom_sel_n = !(active && rom_hit);
  assign ram_sel_n = !(active && ram_hit);
  assign io_sel_n  = !(active && io_hit);
  assign unmapped  = active && !(rom_hit || ram_hit || io_hit);
  assign rom_off   = addr[ROM_OFF_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovl_q <= 1'b1;
    else if (ctrl_wr) ovl_q <= 1'b0;
  end

endmodule

module boot_map_decoder_chk #(
  parameter int ADDR_W    = 24,
  parameter int IO_BASE   = 32'h0040_0000,
  parameter int IO_BYTES  = 32'h0010_0000,
  parameter int VEC_BYTES = 8,
  parameter int CTRL_ADDR = 32'h004F_FFFE,
  parameter int ROM_OFF_W = 17
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:1]    addr,
  input logic                 as_n,
  input logic                 rw,
  input logic                 uds_n,
  input logic                 lds_n,
  input logic                 rom_sel_n,
  input logic                 ram_sel_n,
  input logic                 io_sel_n,
  input logic                 unmapped,
  input logic [ROM_OFF_W-1:1] rom_off,
  input logic                 ovl_q
);
  localparam int AW1 = ADDR_W + 1;
  logic [ADDR_W:0] b;
  logic vec, io, ctl, cwr;
  assign b   = {1'b0, addr, 1'b0};
  assign vec = b < AW1'(VEC_BYTES);
  assign io  = (b >= AW1'(IO_BASE)) && (b < AW1'(IO_BASE + IO_BYTES));
  assign ctl = b == AW1'(CTRL_ADDR);
  assign cwr = !as_n && !rw && (!uds_n || !lds_n) && ctl;

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (rom_sel_n && ram_sel_n && io_sel_n && !unmapped));
  p_io_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && io) |-> !io_sel_n);
  p_vec_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_q && !as_n && rw && vec) |-> (!rom_sel_n && ram_sel_n));
  p_vec_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !rw && vec) |-> (!ram_sel_n && rom_sel_n));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cwr |=> !ovl_q);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_q |=> !ovl_q);
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rom_sel_n, !ram_sel_n, !io_sel_n, unmapped}) <= 1);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_q && !cwr) |=> ovl_q);
  p_vec_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_q && !as_n && rw && vec) |-> (rom_off == addr[ROM_OFF_W-1:1]));
endmodule

bind boot_map_decoder boot_map_decoder_chk #(
  .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_BYTES(IO_BYTES),
  .VEC_BYTES(VEC_BYTES), .CTRL_ADDR(CTRL_ADDR), .ROM_OFF_W(ROM_OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .rw(rw),
  .uds_n(uds_n), .lds_n(lds_n), .rom_sel_n(rom_sel_n),
  .ram_sel_n(ram_sel_n), .io_sel_n(io_sel_n), .unmapped(unmapped),
  .rom_off(rom_off), .ovl_q(ovl_q)
);

// File: tb/boot_map_decoder_tb.sv
`timescale 1ns/1ps
module boot_map_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:1] addr = '0;
  logic as_n = 1'b1, rw = 1'b1, uds_n = 1'b1, lds_n = 1'b1;
  logic rom_sel_n, ram_sel_n, io_sel_n, unmapped;
  logic [16:1] rom_off;

  int tests = 0, fails = 0;
  bit done = 0;
  bit m_ovl;

  always #2 clk = ~clk;

  boot_map_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .rw(rw),
    .uds_n(uds_n), .lds_n(lds_n), .rom_sel_n(rom_sel_n),
    .ram_sel_n(ram_sel_n), .io_sel_n(io_sel_n), .unmapped(unmapped),
    .rom_off(rom_off)
  );

  // behavioural model of the overlay bit
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_ovl <= 1'b1;
    else if (!as_n && !rw && (!uds_n || !lds_n) && ({addr, 1'b0} == 24'h4FFFFE))
      m_ovl <= 1'b0;
  end

  task automatic compare(string tag);
    int b;
    bit e_rom, e_ram, e_io, e_unm;
    int e_off;
    b = int'({addr, 1'b0});
    e_rom = 0; e_ram = 0; e_io = 0; e_unm = 0;
    if (!as_n) begin
      if (m_ovl && rw && b < 8) e_rom = 1;
      else if (b < 32'h40000) e_ram = 1;
      else if (b >= 32'h400000 && b < 32'h500000) e_io = 1;
      else if (b >= 32'hFE0000) e_rom = 1;
      else e_unm = 1;
    end
    e_off = (b % 32'h20000) / 2;
    tests++;
    if (rom_sel_n !== !e_rom || ram_sel_n !== !e_ram || io_sel_n !== !e_io ||
        unmapped !== e_unm || (e_rom && rom_off !== 16'(e_off))) begin
      fails++;
      $display("FAIL %s addr=%06h got rom/ram/io/unm=%b%b%b%b off=%0h exp=%b%b%b%b off=%0h",
               tag, b, rom_sel_n, ram_sel_n, io_sel_n, unmapped, rom_off,
               !e_rom, !e_ram, !e_io, e_unm, e_off);
    end
  endtask

  task automatic acc(string tag, int b, bit a_n, bit r, bit u_n, bit l_n);
    @(negedge clk);
    addr = 23'(b >> 1); as_n = a_n; rw = r; uds_n = u_n; lds_n = l_n;
    #1 compare(tag);
  endtask

  task automatic rd(string tag, int b);  acc(tag, b, 0, 1, 0, 0); endtask
  task automatic wr(string tag, int b);  acc(tag, b, 0, 0, 0, 0); endtask
  task automatic idle(string tag, int b); acc(tag, b, 1, 1, 1, 1); endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle("R1 reset", 0);
    idle("R1 reset", 32'hFE0000);
    @(negedge clk) rst_n = 1'b1;
    idle("R1", 32'h400000);
    // overlay on after reset
    for (int i = 0; i < 8; i += 2) rd("R3 R8 vec read", i);
    rd("R3 byte 8", 8);
    wr("R4 vec write", 0);
    rd("R3 after write", 4);
    wr("R4 vec write", 6);
    rd("R2 ram top", 32'h3FFFE);
    rd("R6 past ram", 32'h40000);
    rd("R6 below io", 32'h3FFFFE);
    rd("R2 io low", 32'h400000);
    rd("R2 io high", 32'h4FFFF0);
    rd("R6 past io", 32'h500000);
    rd("R6 below rom", 32'hFDFFFE);
    rd("R2 R8 rom low", 32'hFE0000);
    rd("R2 R8 rom high", 32'hFFFFFE);
    rd("R2 R8 rom mid", 32'hFF1234);
    // control accesses that must not clear
    rd("R7 R9 ctrl read", 32'h4FFFFE);
    acc("R7 R9 ctrl write no ds", 32'h4FFFFE, 0, 0, 1, 1);
    rd("R7 still overlay", 2);
    wr("R2 io neighbour write", 32'h4FFFFC);
    rd("R7 still overlay", 0);
    // clear and read back next cycle
    acc("R5 R9 ctrl write lds", 32'h4FFFFE, 0, 0, 1, 0);
    rd("R5 vec read after clear", 0);
    rd("R5 vec read after clear", 6);
    rd("R5 stays cleared", 2);
    idle("R1 idle", 0);
    rd("R5 stays cleared", 4);
    // reset brings overlay back
    @(negedge clk) rst_n = 1'b0;
    idle("R1 in reset", 0);
    @(negedge clk) rst_n = 1'b1;
    rd("R5 overlay after reset", 0);
    acc("R5 ctrl write uds", 32'h4FFFFE, 0, 0, 0, 1);
    rd("R5 cleared by uds", 2);
    // random traffic
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < 3000; k++) begin
      int sel, b;
      sel = $urandom_range(0, 5);
      case (sel)
        0: b = $urandom_range(0, 15);
        1: b = $urandom_range(32'h3FFF0, 32'h40010);
        2: b = $urandom_range(32'h3FFFF0, 32'h400010);
        3: b = $urandom_range(32'h4FFFF0, 32'h500010);
        4: b = $urandom_range(32'hFDFFF0, 32'hFFFFFF);
        default: b = (k % 50 == 0) ? 32'h4FFFFE : $urandom_range(0, 32'hFFFFFF);
      endcase
      if (k % 700 == 0) begin
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
      end
      acc("R2 R3 R4 R5 R6 random", b & 32'hFFFFFE, 1'($urandom_range(0, 3) == 0),
          1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule